// File: doc/BRIEF.md
# Multiple-Interval Status Timer

This block raises a sticky status flag at a fixed, programmable interval. A free-running prescaler divides the system clock into a base tick, nominally 100 ms, whose length in clocks is set by a parameter. A small counter counts base ticks. When it reaches the programmed multiple, which may be one to five ticks, the interval expires. The counter then restarts on its own, and the expiry sets an output latch.

Software programs the multiple through a decoded register write port. One address of that port selects the timer. Writes to any other address belong to neighbouring functions and are ignored here. The flag stays set until a status-read strobe clears it, so a controller that polls late still sees that at least one interval has passed. There is no streaming data path, and every pin is a plain control or status signal.

Top module: `ivl_status_timer`

## Requirements
- R1: While reset is asserted and directly after it, the flag is 0, the multiple is 1, and the interval starts counting from the release of reset.
- R2: The base tick recurs every TICK_CLKS system clocks, so with a multiple of 1 the flag sets exactly TICK_CLKS clocks after the interval starts.
- R3: A write with wr_en=1 and wr_addr equal to TMR_ADDR (default 2) loads the multiple from wr_data. For values 1 to 5, the flag sets exactly value*TICK_CLKS clocks after that write's clock edge.
- R4: A written value of 0, or any value from 6 to 63, is treated as a multiple of 1.
- R5: A write to any address other than TMR_ADDR changes neither the multiple nor the timing of the running interval.
- R6: After each expiry the interval restarts automatically, so expiries recur every multiple*TICK_CLKS clocks.
- R7: Once set, the flag holds until rd_stb is sampled high. The flag then reads 0 from the next cycle on, unless an expiry coincides.
- R8: An expiry sets the flag whether or not the previous flag was read.
- R9: If rd_stb and an expiry fall in the same cycle, the flag ends up set.
- R10: A timer write restarts the prescaler and the interval count. An expiry that would fall on the edge of that write does not happen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Decoded register target |
| wr_data | input | DATA_W | Write data; the multiple for the timer target |
| rd_stb | input | 1 | Status-read strobe; clears the flag |
| ivl_flag | output | 1 | Latched interval-expired flag |

## Verification
The hardest situations to reach from the ports are the coincidences: a status read, or a new timer write, landing on the exact edge where an interval expires. The bench uses a tiny TICK_CLKS. It counts clocks from a write whose edge is known, so that it can place the read strobe, or a second write, on that expiry edge. A behavioural cycle model is compared with the flag on every clock throughout, including during long stretches in which the flag is left unread across several expiries.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;
  localparam int MULT_MAX = 5;
  localparam int MULT_W   = $clog2(MULT_MAX + 1);
  typedef logic [MULT_W-1:0] mult_t;
endpackage

// File: rtl/ivl_tick_gen.sv
module ivl_tick_gen #(
  parameter int TICK_CLKS = 10_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int CW = (TICK_CLKS > 1) ? $clog2(TICK_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CLKS - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  assert_restart_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));
endmodule

// File: rtl/ivl_interval_cnt.sv
module ivl_interval_cnt
  import ivl_timer_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  restart,
  input  logic  tick,
  input  mult_t mult,
  output logic  expire
);
  mult_t icnt;
  logic  last;

  assign last   = (icnt == mult - 1'b1);
  assign expire = tick && last && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       icnt <= '0;
    else if (restart) icnt <= '0;
    else if (tick)    icnt <= last ? '0 : icnt + 1'b1;
  end

  assert_icnt_below_R6: assert property (@(posedge clk) disable iff (!rst_n)
    icnt < mult);
  assert_rearm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (icnt == '0));
endmodule

// File: rtl/ivl_flag_latch.sv
module ivl_flag_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q);
  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !q);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !set) |=> $stable(q));
endmodule

// File: rtl/ivl_status_timer.sv
module ivl_status_timer
  import ivl_timer_pkg::*;
#(
  parameter int                TICK_CLKS = 10_000_000,
  parameter int                ADDR_W    = 2,
  parameter int                DATA_W    = 6,
  parameter logic [ADDR_W-1:0] TMR_ADDR  = 2'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_stb,
  output logic              ivl_flag
);
  logic  wr_hit;
  logic  tick;
  logic  expire;
  mult_t mult_q;
  mult_t mult_in;

  assign wr_hit = wr_en && (wr_addr == TMR_ADDR);

  always_comb begin
    if (wr_data >= DATA_W'(1) && wr_data <= DATA_W'(MULT_MAX))
      mult_in = mult_t'(wr_data);
    else
      mult_in = mult_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mult_q <= mult_t'(1);
    else if (wr_hit) mult_q <= mult_in;
  end

  ivl_tick_gen #(.TICK_CLKS(TICK_CLKS)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(wr_hit), .tick(tick)
  );

  ivl_interval_cnt u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(wr_hit), .tick(tick),
    .mult(mult_q), .expire(expire)
  );

  ivl_flag_latch u_flag (
    .clk(clk), .rst_n(rst_n), .set(expire), .clr(rd_stb), .q(ivl_flag)
  );

  assert_mult_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mult_q >= mult_t'(1)) && (mult_q <= mult_t'(MULT_MAX)));
  assert_foreign_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != TMR_ADDR) |=> $stable(mult_q));
  assert_no_expire_on_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && rd_stb) |=> !ivl_flag);
endmodule

// File: tb/test_ivl_status_timer.sv
module test_ivl_status_timer;
  localparam int T = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [5:0] wr_data = 6'd0;
  logic       rd_stb = 1'b0;
  logic       ivl_flag;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  int m_elapsed = 0;
  int m_mult = 1;
  bit m_flag = 1'b0;

  always #5 clk = ~clk;

  ivl_status_timer #(.TICK_CLKS(T)) i_ivl_status_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_stb(rd_stb), .ivl_flag(ivl_flag)
  );

  // behavioural reference: elapsed clocks since interval start
  always @(posedge clk) begin
    bit ex;
    if (!rst_n) begin
      m_elapsed = 0; m_mult = 1; m_flag = 1'b0;
    end else begin
      ex = 1'b0;
      if (wr_en && wr_addr == 2'd2) begin
        m_elapsed = 0;
        m_mult = (wr_data >= 1 && wr_data <= 5) ? int'(wr_data) : 1;
      end else begin
        m_elapsed++;
        if (m_elapsed == m_mult * T) begin ex = 1'b1; m_elapsed = 0; end
      end
      m_flag = ex | (m_flag & ~rd_stb);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!done) check(ivl_flag === m_flag, cur_req, int'(ivl_flag), int'(m_flag));
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      check(1'b0, "watchdog", cyc, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [5:0] d, input bit rd);
    wr_en = 1'b1; wr_addr = a; wr_data = d; rd_stb = rd;
    @(negedge clk);
    wr_en = 1'b0; rd_stb = 1'b0;
  endtask

  task automatic read_pulse();
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  // counts clocks from now until the flag is seen
  task automatic measure(output int n);
    n = 0;
    while (!ivl_flag && n < 200) begin @(negedge clk); n++; end
  endtask

  initial begin
    int n;
    idle(3);
    cur_req = "R1";
    check(ivl_flag == 1'b0, "R1", int'(ivl_flag), 0);
    @(negedge clk);
    rst_n = 1'b1;
    measure(n);
    check(n == T, "R1", n, T);

    cur_req = "R2";
    read_pulse();
    measure(n);
    check(n == T - 1, "R2", n, T - 1);

    cur_req = "R3";
    for (int m = 1; m <= 5; m++) begin
      wr(2'd2, 6'(m), 1'b1);
      measure(n);
      check(n == m * T, "R3", n, m * T);
    end

    cur_req = "R4";
    wr(2'd2, 6'd0, 1'b1);  measure(n); check(n == T, "R4", n, T);
    wr(2'd2, 6'd7, 1'b1);  measure(n); check(n == T, "R4", n, T);
    wr(2'd2, 6'd63, 1'b1); measure(n); check(n == T, "R4", n, T);

    cur_req = "R5";
    wr(2'd2, 6'd3, 1'b1);
    idle(4);
    wr(2'd1, 6'd5, 1'b0);
    measure(n);
    check(n == 3 * T - 5, "R5", n, 3 * T - 5);

    cur_req = "R6";
    wr(2'd2, 6'd2, 1'b1);
    measure(n);
    read_pulse();
    measure(n);
    check(n == 2 * T - 1, "R6", n, 2 * T - 1);

    cur_req = "R7";
    wr(2'd2, 6'd5, 1'b1);
    measure(n);
    idle(8);
    check(ivl_flag == 1'b1, "R7", int'(ivl_flag), 1);
    read_pulse();
    check(ivl_flag == 1'b0, "R7", int'(ivl_flag), 0);

    cur_req = "R8";
    wr(2'd2, 6'd1, 1'b1);
    idle(5 * T + 2);
    check(ivl_flag == 1'b1, "R8", int'(ivl_flag), 1);

    cur_req = "R9";
    wr(2'd2, 6'd1, 1'b1);
    idle(T - 1);
    read_pulse();
    check(ivl_flag == 1'b1, "R9", int'(ivl_flag), 1);

    cur_req = "R10";
    wr(2'd2, 6'd4, 1'b1);
    idle(10);
    wr(2'd2, 6'd4, 1'b0);
    measure(n);
    check(n == 4 * T, "R10", n, 4 * T);
    wr(2'd2, 6'd1, 1'b1);
    idle(T - 1);
    wr(2'd2, 6'd1, 1'b0);
    check(ivl_flag == 1'b0, "R10", int'(ivl_flag), 0);
    measure(n);
    check(n == T, "R10", n, T);

    idle(3);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule